// File: doc/BRIEF.md
# Descriptor condition evaluator for interrupt, branch and wait

This unit sits beside the sequencer of a descriptor-driven DMA channel. For the descriptor now being executed it works out three decisions from the four device-status bits: whether the channel must stall and retry the command, whether an interrupt is raised when the command completes, and whether the next descriptor comes from the branch target or from the following slot.

Each decision has its own select word, and a match test against the device status is applied to that word. The select word carries a mask in bits 19:16 and a compare value in bits 3:0. The test is true when the masked status equals the masked compare value. A 2-bit mode field taken from the command word then turns that test into an action. The four modes are never, act when the test is true, act when the test is false, and always.

The stall decision is combinational, so the sequencer can hold the command in the same cycle. The interrupt and the branch outcome are registered. Each appears for one cycle after the sequencer's completion strobe, and only if that completion was not stalled.

Top module: `cibw_unit`

## Requirements
- R1: A select word's test is true exactly when (dev_stat_i & sel[19:16]) equals (sel[3:0] & sel[19:16]). Each decision uses only its own select word: irq_sel_i for the interrupt, br_sel_i for the branch, and wait_sel_i for the wait.
- R2: The mode fields are cmd_i[5:4] for the interrupt, cmd_i[3:2] for the branch and cmd_i[1:0] for the wait. They are encoded as 0 = never, 1 = act if the test is true, 2 = act if the test is false, 3 = always. Other bits of cmd_i have no effect.
- R3: stall_o is the qualified wait decision. It follows the current inputs in the same cycle, whether or not done_i is high.
- R4: When done_i is high and stall_o is low, irq_o is high in the following cycle exactly when the qualified interrupt decision is true. irq_o is low in every other cycle.
- R5: When done_i is high and stall_o is low, exactly one of branch_o and step_o is high in the following cycle. branch_o is high when the qualified branch decision is true, and step_o is high otherwise. Branch mode 0 therefore always gives step_o, and branch mode 3 always gives branch_o.
- R6: A completion while stall_o is high gives no irq_o, no branch_o and no step_o in the following cycle, whatever the interrupt and branch modes are.
- R7: While rst_n is low at a clock edge, irq_o, branch_o and step_o are low in the following cycle.
- R8: A mask of zero makes the test true for any device status. With a zero mask, mode 1 always acts and mode 2 never acts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| done_i | input | 1 | Completion strobe from the sequencer for the current command |
| cmd_i | input | 16 | Command word of the current descriptor |
| dev_stat_i | input | 4 | Device-status bits |
| irq_sel_i | input | 32 | Interrupt select word (mask 19:16, value 3:0) |
| br_sel_i | input | 32 | Branch select word (mask 19:16, value 3:0) |
| wait_sel_i | input | 32 | Wait select word (mask 19:16, value 3:0) |
| irq_o | output | 1 | One-cycle interrupt pulse |
| branch_o | output | 1 | One-cycle pulse: take the branch target |
| step_o | output | 1 | One-cycle pulse: advance to the next descriptor |
| stall_o | output | 1 | Wait decision: hold and retry the command |

## Verification
The assertions assume that done_i, cmd_i, dev_stat_i and the select words are stable across each clock edge. They also assume that the outputs registered after a completion reflect the inputs sampled at that same edge. The bench meets these assumptions by changing every input only on the falling edge. It holds done_i for single cycles and also for runs of consecutive cycles. Stimulus covers every mode of every decision, both with and without a stalling wait. It also covers zero, partial and full masks. A long pseudo-random phase mixes in completions that arrive while a stall is active.

// File: rtl/cibw_pkg.sv
// Package: shared encodings of the condition evaluator.
// Assumes a 2-bit mode field per decision in the command word.
package cibw_pkg;
    typedef enum logic [1:0] {
        MODE_NEVER    = 2'd0,
        MODE_IF_TRUE  = 2'd1,
        MODE_IF_FALSE = 2'd2,
        MODE_ALWAYS   = 2'd3
    } act_mode_e;

    localparam int LANES    = 3;
    localparam int LANE_IRQ = 0;
    localparam int LANE_BR  = 1;
    localparam int LANE_WT  = 2;
endpackage

// File: rtl/cibw_match.sv
// Module: masked match of the device status against one select word.
// Assumes the mask and the compare value sit in one word at MASK_LSB and VAL_LSB.
module cibw_match #(
    parameter int STAT_W   = 4,
    parameter int SEL_W    = 32,
    parameter int MASK_LSB = 16,
    parameter int VAL_LSB  = 0
) (
    input  logic [STAT_W-1:0] stat_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              hit_o
);
    logic [STAT_W-1:0] mask;
    logic [STAT_W-1:0] value;

    // Extract the fields and compare the masked status with the masked value.
    always_comb begin
        mask  = sel_i[MASK_LSB +: STAT_W];
        value = sel_i[VAL_LSB +: STAT_W];
        hit_o = ((stat_i & mask) == (value & mask));
    end

    // R8: an empty mask accepts every status.
    always_comb begin
        if (sel_i[MASK_LSB +: STAT_W] == '0) begin
            a_r8_empty_mask_hits: assert (hit_o);
        end
    end
endmodule

// File: rtl/cibw_qual.sv
// Module: turns a match result into an action according to a 2-bit mode.
// Assumes the encoding of cibw_pkg::act_mode_e.
module cibw_qual
    import cibw_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       hit_i,
    output logic       act_o
);
    // Select the action for the current mode.
    always_comb begin
        unique case (act_mode_e'(mode_i))
            MODE_NEVER:    act_o = 1'b0;
            MODE_IF_TRUE:  act_o = hit_i;
            MODE_IF_FALSE: act_o = ~hit_i;
            MODE_ALWAYS:   act_o = 1'b1;
            default:       act_o = 1'b0;
        endcase
    end

    // R2: the if-true and if-false modes give opposite actions for the same match.
    always_comb begin
        if (mode_i == MODE_IF_TRUE) begin
            a_r2_if_true_follows: assert (act_o == hit_i);
        end
        if (mode_i == MODE_IF_FALSE) begin
            a_r2_if_false_inverts: assert (act_o != hit_i);
        end
    end
endmodule

// File: rtl/cibw_unit.sv
// Module: conditional interrupt, branch and wait evaluator for one descriptor.
// The stall decision is combinational. The interrupt and the branch/step
// outcome are registered pulses, qualified by the sequencer's completion
// strobe. Assumes inputs are stable around each rising clock edge.
module cibw_unit
    import cibw_pkg::*;
#(
    parameter int CMD_W    = 16,
    parameter int STAT_W   = 4,
    parameter int SEL_W    = 32,
    parameter int MASK_LSB = 16,
    parameter int VAL_LSB  = 0,
    parameter int IRQ_LSB  = 4,
    parameter int BR_LSB   = 2,
    parameter int WAIT_LSB = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [STAT_W-1:0] dev_stat_i,
    input  logic [SEL_W-1:0]  irq_sel_i,
    input  logic [SEL_W-1:0]  br_sel_i,
    input  logic [SEL_W-1:0]  wait_sel_i,
    output logic              irq_o,
    output logic              branch_o,
    output logic              step_o,
    output logic              stall_o
);
    logic [SEL_W-1:0] sel_arr [LANES];
    logic [LANES-1:0] hit;
    logic [LANES-1:0] act;
    logic             commit;

    // Route each select word to its lane.
    always_comb begin
        sel_arr[LANE_IRQ] = irq_sel_i;
        sel_arr[LANE_BR]  = br_sel_i;
        sel_arr[LANE_WT]  = wait_sel_i;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LSB = (g == LANE_IRQ) ? IRQ_LSB :
                             (g == LANE_BR)  ? BR_LSB  : WAIT_LSB;

        cibw_match #(
            .STAT_W  (STAT_W),
            .SEL_W   (SEL_W),
            .MASK_LSB(MASK_LSB),
            .VAL_LSB (VAL_LSB)
        ) u_match (
            .stat_i(dev_stat_i),
            .sel_i (sel_arr[g]),
            .hit_o (hit[g])
        );

        cibw_qual u_qual (
            .mode_i(cmd_i[LSB +: 2]),
            .hit_i (hit[g]),
            .act_o (act[g])
        );
    end

    // The wait decision leaves the block at once.
    assign stall_o = act[LANE_WT];
    assign commit  = done_i & ~act[LANE_WT];

    // Register the completion outcome as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o    <= 1'b0;
            branch_o <= 1'b0;
            step_o   <= 1'b0;
        end else begin
            irq_o    <= commit & act[LANE_IRQ];
            branch_o <= commit & act[LANE_BR];
            step_o   <= commit & ~act[LANE_BR];
        end
    end

    // R4: an interrupt pulse follows only an unstalled completion.
    a_r4_irq_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(done_i) && !$past(stall_o)));

    // R5: an unstalled completion yields exactly one next-descriptor choice.
    a_r5_one_choice: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !stall_o) |=> (branch_o != step_o));

    // R5: no choice is made without a completion.
    a_r5_choice_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_o || step_o) |-> $past(done_i));

    // R6: a stalled completion has no effect.
    a_r6_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && stall_o) |=> !(irq_o || branch_o || step_o));

    // R3: the always-wait mode stalls in the same cycle.
    a_r3_always_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i[WAIT_LSB +: 2] == MODE_ALWAYS) |-> stall_o);
endmodule

// File: tb/tb_cibw_unit.sv
module tb_cibw_unit;
    localparam int PERIOD = 10;

    typedef struct {
        bit    irq;
        bit    br;
        bit    st;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done_i = 1'b0;
    logic [15:0] cmd_i = '0;
    logic [3:0]  dev_stat_i = '0;
    logic [31:0] irq_sel_i = '0;
    logic [31:0] br_sel_i = '0;
    logic [31:0] wait_sel_i = '0;
    logic        irq_o, branch_o, step_o, stall_o;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    exp_t sb[$];
    logic [31:0] lfsr = 32'h1234_5678;

    cibw_unit dut (
        .clk(clk), .rst_n(rst_n), .done_i(done_i), .cmd_i(cmd_i),
        .dev_stat_i(dev_stat_i), .irq_sel_i(irq_sel_i), .br_sel_i(br_sel_i),
        .wait_sel_i(wait_sel_i), .irq_o(irq_o), .branch_o(branch_o),
        .step_o(step_o), .stall_o(stall_o)
    );

    always #(PERIOD/2) clk = ~clk;

    // R1: masked match; mask in bits 19:16, value in bits 3:0.
    function automatic bit m_hit(input logic [3:0] st, input logic [31:0] sel);
        return ((st & sel[19:16]) == (sel[3:0] & sel[19:16]));
    endfunction

    // R2: 0 never, 1 if true, 2 if false, 3 always.
    function automatic bit m_act(input logic [1:0] mode, input bit h);
        case (mode)
            2'd0: return 1'b0;
            2'd1: return h;
            2'd2: return !h;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of inputs at the falling edge and queues the outcome.
    task automatic drive(input logic [15:0] cmd, input logic [3:0] st,
                         input logic [31:0] is, input logic [31:0] bs,
                         input logic [31:0] ws, input bit dn, input string tag);
        exp_t e;
        bit   stall, ir, br;
        @(negedge clk);
        cmd_i = cmd; dev_stat_i = st; irq_sel_i = is; br_sel_i = bs;
        wait_sel_i = ws; done_i = dn;
        stall = m_act(cmd[1:0], m_hit(st, ws));
        ir    = m_act(cmd[5:4], m_hit(st, is));
        br    = m_act(cmd[3:2], m_hit(st, bs));
        e.tag = tag;
        if (!rst_n) begin
            e.irq = 0; e.br = 0; e.st = 0; e.tag = "R7";
        end else begin
            e.irq = dn && !stall && ir;
            e.br  = dn && !stall && br;
            e.st  = dn && !stall && !br;
        end
        sb.push_back(e);
        #1;
        check({tag, " R3"}, "stall_o", stall_o, stall);
    endtask

    // Monitor: compares the registered outputs after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "irq_o", irq_o, e.irq);
                check(e.tag, "branch_o", branch_o, e.br);
                check(e.tag, "step_o", step_o, e.st);
            end
        end
    end

    // Watchdog.
    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [31:0] ZM = 32'h0000_0000;

    initial begin
        // R7: reset state, with a completion pending that must be ignored.
        for (int i = 0; i < 3; i++) drive(16'h003C, 4'h0, ZM, ZM, ZM, 1'b1, "R7");
        @(negedge clk);
        rst_n = 1'b1;
        // R4 R5: no completion, no pulses.
        drive(16'h0030, 4'h0, ZM, ZM, ZM, 1'b0, "R4");
        // R5: branch never gives step; branch always gives branch.
        drive(16'h0000, 4'h5, ZM, ZM, ZM, 1'b1, "R5_never");
        drive(16'h000C, 4'h5, ZM, ZM, ZM, 1'b1, "R5_always");
        // R4: interrupt always and never.
        drive(16'h0030, 4'h0, ZM, ZM, ZM, 1'b1, "R4_always");
        drive(16'h0000, 4'h0, ZM, ZM, ZM, 1'b1, "R4_never");
        // R1: mask 0xC value 0x8: status 0x9 matches, 0x5 does not.
        drive(16'h0014, 4'h9, 32'h000C_0008, 32'h000C_0008, ZM, 1'b1, "R1_match");
        drive(16'h0014, 4'h5, 32'h000C_0008, 32'h000C_0008, ZM, 1'b1, "R1_miss");
        drive(16'h0028, 4'h9, 32'h000C_0008, 32'h000C_0008, ZM, 1'b1, "R1_iffalse");
        drive(16'h0028, 4'h5, 32'h000C_0008, 32'h000C_0008, ZM, 1'b1, "R1_iffalse2");
        // R1: separate select words per decision.
        drive(16'h0014, 4'h3, 32'h000F_0003, 32'h000F_000C, ZM, 1'b1, "R1_separate");
        // R8: empty mask, if-true acts and if-false does not.
        drive(16'h0014, 4'hA, 32'h0000_0005, 32'h0000_0005, ZM, 1'b1, "R8_true");
        drive(16'h0028, 4'hA, 32'h0000_0005, 32'h0000_0005, ZM, 1'b1, "R8_false");
        // R3 R6: wait always stalls the completion.
        drive(16'h003F, 4'h0, ZM, ZM, ZM, 1'b1, "R6_always");
        // R3: wait if-true with matching status, done low.
        drive(16'h0001, 4'h2, ZM, ZM, 32'h0002_0002, 1'b0, "R3_iftrue");
        drive(16'h0031, 4'h2, ZM, ZM, 32'h0002_0002, 1'b1, "R6_iftrue");
        drive(16'h0031, 4'h0, ZM, ZM, 32'h0002_0002, 1'b1, "R6_released");
        drive(16'h003E, 4'h0, ZM, ZM, 32'h0002_0002, 1'b1, "R6_iffalse");
        drive(16'h003E, 4'h2, ZM, ZM, 32'h0002_0002, 1'b1, "R6_iffalse_go");
        // R2: upper command bits have no effect.
        drive(16'hFFC0, 4'h0, ZM, ZM, ZM, 1'b1, "R2_upper");
        drive(16'hFFF0, 4'h0, ZM, ZM, ZM, 1'b1, "R2_upper_irq");
        // R4: back-to-back completions each give one pulse.
        for (int i = 0; i < 4; i++) drive(16'h0030, 4'h0, ZM, ZM, ZM, 1'b1, "R4_b2b");
        // R4 R5 R6: pseudo-random mix.
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, b, c;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            a = lfsr;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            b = lfsr;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            c = lfsr;
            drive(a[15:0], b[3:0], {12'h0, a[19:16], 12'h0, a[23:20]},
                  {12'h0, b[19:16], 12'h0, b[23:20]},
                  {12'h0, c[19:16], 12'h0, c[23:20]}, c[0] | c[1], "R4 R5 R6 rand");
        end
        drive(16'h0000, 4'h0, ZM, ZM, ZM, 1'b0, "R5_idle");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule